// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between an 8-bit CPU with a 16-bit logical address bus and a 16-bit-wide external SRAM. It holds one 8-bit page entry for each of the sixteen 4 KB logical pages. For every access it produces a 17-bit physical SRAM address and picks one byte lane of the wide memory. It then drives the active-low chip select, the two active-low lane write strobes and the tri-stated data lanes, and it steers the chosen byte back to the CPU.

Page entries are loaded by CPU writes to the top 8 KB window of the logical space. The outer address decoder flags that window with a map-write-select input and flags ordinary RAM cycles with a RAM-select input. The write selects its entry by the low four address bits, while translation selects its entry by the high four address bits. The entry in use is visible on an output, so software-side state, including the two spare high bits, can be observed.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, entry i holds the value 2*i, so logical page i maps to physical page i on the upper lane; an asserted reset restores these values at once.
- R2: An entry is written on the rising clock edge when map_wr_sel, cpu_vma are 1 and cpu_rw is 0; the entry index is cpu_addr[3:0] and the value is cpu_wdata.
- R3: A cycle with cpu_rw = 1 or cpu_vma = 0 leaves every entry unchanged, even when map_wr_sel is 1.
- R4: Translation in the same cycle as an entry write uses the entry's old value; the new value applies from the next cycle.
- R5: sram_addr[16:12] equals bits 5:1 of the entry chosen by cpu_addr[15:12], and sram_addr[11:0] equals cpu_addr[11:0]; map_entry shows that entry.
- R6: Entry bit 0 picks the lane: 0 returns sram_dq[15:8] on cpu_rdata, 1 returns sram_dq[7:0].
- R7: sram_we_hi_n (lane bit 0) or sram_we_lo_n (lane bit 1) is low only while cpu_rw is 0, clk is high and that lane is picked; the other strobe stays high.
- R8: A data lane carries cpu_wdata only while its write strobe is low; otherwise it is high-impedance.
- R9: sram_ce_n is low only when ram_sel is 1 and rst_n is 1.
- R10: Entry bits 7:6 are stored and shown on map_entry but do not change sram_addr or the lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; also times the write strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Logical address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_vma | input | 1 | Valid memory access |
| cpu_wdata | input | 8 | Write byte from the CPU |
| cpu_rdata | output | 8 | Byte returned from the picked lane |
| ram_sel | input | 1 | Outer decode: this cycle targets RAM |
| map_wr_sel | input | 1 | Outer decode: this cycle targets the page window |
| map_entry | output | 8 | Entry currently used for translation |
| sram_ce_n | output | 1 | SRAM chip select, active low |
| sram_we_hi_n | output | 1 | Upper-lane write strobe, active low |
| sram_we_lo_n | output | 1 | Lower-lane write strobe, active low |
| sram_addr | output | 17 | Physical SRAM address |
| sram_dq | inout | 16 | SRAM data, two byte lanes |

## Verification
The hardest case is a write that lands on the very entry the same cycle is translating through, because only then does the old-versus-new ordering become visible. The stimulus reaches it by writing through an address whose high and low nibbles are equal, so the write index and the lookup index coincide, and samples map_entry once before and once after the rising edge. The strobe and lane checks sample inside both clock phases of one write cycle, since the strobes exist only while the clock is high.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  typedef enum logic {
    LANE_HI = 1'b0,
    LANE_LO = 1'b1
  } lane_e;
endpackage

// File: rtl/pxu_rst_sync.sv
module pxu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pxu_page_regs.sv
module pxu_page_regs #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int N_PAGES = 1 << IDX_W;

  logic [N_PAGES-1:0][DATA_W-1:0] map_q;
  logic [N_PAGES-1:0][DATA_W-1:0] map_d;

  always_comb begin
    map_d = map_q;
    map_d[wr_idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PAGES; i++) map_q[i] <= DATA_W'(i) << 1;
    end else if (wr_en) begin
      map_q <= map_d;
    end
  end

  // Lookup reads the stored value, so a same-cycle write is not seen yet.
  assign rd_data = map_q[rd_idx];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_q[$past(wr_idx)] == $past(wr_data));

  p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(map_q));
endmodule

// File: rtl/pxu_lane_bridge.sv
module pxu_lane_bridge
  import pxu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                cpu_rw,
  input  lane_e               lane,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [2*DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0]   rdata,
  output logic [2*DATA_W-1:0] dq_out,
  output logic                oe_hi,
  output logic                oe_lo,
  output logic                we_hi_n,
  output logic                we_lo_n
);
  logic wr_phase;

  assign wr_phase = !cpu_rw && clk;
  assign oe_hi    = wr_phase && (lane == LANE_HI);
  assign oe_lo    = wr_phase && (lane == LANE_LO);
  assign we_hi_n  = !oe_hi;
  assign we_lo_n  = !oe_lo;
  assign dq_out   = {wdata, wdata};

  always_comb begin
    if (lane == LANE_HI) rdata = dq_in[2*DATA_W-1:DATA_W];
    else                 rdata = dq_in[DATA_W-1:0];
  end

  // Strobes seen across the high phase: never both lanes at once.
  p_one_lane_r7: assert property (@(negedge clk)
    !(!we_hi_n && !we_lo_n));
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pxu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int PPN_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic                      cpu_rw,
  input  logic                      cpu_vma,
  input  logic [DATA_W-1:0]         cpu_wdata,
  output logic [DATA_W-1:0]         cpu_rdata,
  input  logic                      ram_sel,
  input  logic                      map_wr_sel,
  output logic [DATA_W-1:0]         map_entry,
  output logic                      sram_ce_n,
  output logic                      sram_we_hi_n,
  output logic                      sram_we_lo_n,
  output logic [PPN_W+ADDR_W-IDX_W-1:0] sram_addr,
  inout  wire  [2*DATA_W-1:0]       sram_dq
);
  localparam int OFFS_W = ADDR_W - IDX_W;

  logic                rst_sync_n;
  logic                map_wr_en;
  lane_e               lane;
  logic [2*DATA_W-1:0] dq_out;
  logic                oe_hi;
  logic                oe_lo;

  pxu_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_sync_n)
  );

  assign map_wr_en = map_wr_sel && cpu_vma && !cpu_rw;

  pxu_page_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_map (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (map_wr_en),
    .wr_idx (cpu_addr[IDX_W-1:0]),
    .wr_data(cpu_wdata),
    .rd_idx (cpu_addr[ADDR_W-1 -: IDX_W]),
    .rd_data(map_entry)
  );

  assign lane      = lane_e'(map_entry[0]);
  assign sram_addr = {map_entry[PPN_W:1], cpu_addr[OFFS_W-1:0]};
  assign sram_ce_n = !(ram_sel && rst_n);

  pxu_lane_bridge #(.DATA_W(DATA_W)) u_lane (
    .clk    (clk),
    .cpu_rw (cpu_rw),
    .lane   (lane),
    .wdata  (cpu_wdata),
    .dq_in  (sram_dq),
    .rdata  (cpu_rdata),
    .dq_out (dq_out),
    .oe_hi  (oe_hi),
    .oe_lo  (oe_lo),
    .we_hi_n(sram_we_hi_n),
    .we_lo_n(sram_we_lo_n)
  );

  assign sram_dq[2*DATA_W-1:DATA_W] = oe_hi ? dq_out[2*DATA_W-1:DATA_W] : 'z;
  assign sram_dq[DATA_W-1:0]        = oe_lo ? dq_out[DATA_W-1:0]        : 'z;

  p_ce_off_in_reset_r9: assert property (@(posedge clk)
    !rst_n |-> sram_ce_n);

  p_no_ce_without_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel |-> sram_ce_n);
endmodule

// File: tb/test_page_xlate_unit.sv
module test_page_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_rw;
  logic        cpu_vma;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        ram_sel;
  logic        map_wr_sel;
  logic [7:0]  map_entry;
  logic        sram_ce_n;
  logic        sram_we_hi_n;
  logic        sram_we_lo_n;
  logic [16:0] sram_addr;
  wire  [15:0] sram_dq;
  logic [15:0] tb_dq;
  logic        tb_dq_en;
  int          n_chk = 0;
  int          n_fail = 0;

  assign sram_dq = tb_dq_en ? tb_dq : 'z;

  always #5 clk = ~clk;

  page_xlate_unit i_page_xlate_unit (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_vma(cpu_vma), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ram_sel(ram_sel), .map_wr_sel(map_wr_sel), .map_entry(map_entry),
    .sram_ce_n(sram_ce_n), .sram_we_hi_n(sram_we_hi_n),
    .sram_we_lo_n(sram_we_lo_n), .sram_addr(sram_addr), .sram_dq(sram_dq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_rw = 1'b1; cpu_vma = 1'b0; map_wr_sel = 1'b0; ram_sel = 1'b0;
  endtask

  task automatic map_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rw = 1'b0; cpu_vma = 1'b1; map_wr_sel = 1'b1;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    idle(); cpu_addr = 16'h0000; cpu_wdata = 8'h00; tb_dq_en = 1'b0; tb_dq = '0;
    rst_n = 1'b0; ram_sel = 1'b1;
    #3 check("R9 ce in reset", 32'(sram_ce_n), 32'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R9 ce selected", 32'(sram_ce_n), 32'd0);
    ram_sel = 1'b0;
    #1 check("R9 ce unselected", 32'(sram_ce_n), 32'd1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      cpu_addr = {4'(i), 12'hABC};
      #1;
      check("R1 reset entry", 32'(map_entry), 32'(2 * i));
      check("R5 identity addr", 32'(sram_addr), 32'({5'(i), 12'hABC}));
    end
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cpu_addr = 16'hE00E; cpu_wdata = 8'h5A; cpu_rw = 1'b0; cpu_vma = 1'b1; map_wr_sel = 1'b1;
    #3 check("R4 old entry before edge", 32'(map_entry), 32'h1C);
    @(negedge clk);
    idle();
    #1 check("R4 new entry after edge", 32'(map_entry), 32'h5A);
  endtask

  task automatic t_spare_bits();
    map_write(16'hE005, 8'hC7);
    cpu_addr = 16'h5123;
    #1 check("R2 entry written", 32'(map_entry), 32'hC7);
    check("R10 addr with spare bits set", 32'(sram_addr), 32'({5'd3, 12'h123}));
    map_write(16'hFFF5, 8'h07);
    cpu_addr = 16'h5123;
    #1 check("R10 spare bits stored", 32'(map_entry), 32'h07);
    check("R10 addr with spare bits clear", 32'(sram_addr), 32'({5'd3, 12'h123}));
  endtask

  task automatic t_ignored();
    @(negedge clk);
    cpu_addr = 16'hE003; cpu_wdata = 8'hFF; cpu_rw = 1'b1; cpu_vma = 1'b1; map_wr_sel = 1'b1;
    @(negedge clk);
    cpu_rw = 1'b0; cpu_vma = 1'b0;
    @(negedge clk);
    idle(); cpu_addr = 16'h3000;
    #1 check("R3 read and invalid write ignored", 32'(map_entry), 32'h06);
  endtask

  task automatic t_read_lanes();
    @(negedge clk);
    tb_dq_en = 1'b1; tb_dq = 16'hA55A; cpu_rw = 1'b1; cpu_vma = 1'b1; ram_sel = 1'b1;
    cpu_addr = 16'h3000;
    #2 check("R6 upper lane read", 32'(cpu_rdata), 32'hA5);
    cpu_addr = 16'h5000;
    #2 check("R6 lower lane read", 32'(cpu_rdata), 32'h5A);
    @(posedge clk);
    #2 check("R7 no strobe on read", 32'({sram_we_hi_n, sram_we_lo_n}), 32'b11);
    @(negedge clk);
    idle(); tb_dq_en = 1'b0;
  endtask

  task automatic t_write_lane(input logic [15:0] a, input bit lo);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = 8'h3C; cpu_rw = 1'b0; cpu_vma = 1'b1; ram_sel = 1'b1;
    #2;
    check("R7 strobes off while clk low", 32'({sram_we_hi_n, sram_we_lo_n}), 32'b11);
    check("R8 lanes released while clk low", 32'(sram_dq), {16'h0, 16'hzzzz});
    @(posedge clk);
    #2;
    check("R7 picked strobe while clk high", 32'({sram_we_hi_n, sram_we_lo_n}),
          lo ? 32'b10 : 32'b01);
    check("R8 lane data while clk high", 32'(sram_dq),
          lo ? {16'h0, 8'hzz, 8'h3C} : {16'h0, 8'h3C, 8'hzz});
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 1'b0; ram_sel = 1'b1; cpu_addr = 16'h5000;
    #2 check("R9 ce off at reset", 32'(sram_ce_n), 32'd1);
    check("R1 entry restored", 32'(map_entry), 32'h0A);
    @(negedge clk);
    rst_n = 1'b1; idle();
  endtask

  initial begin
    t_reset();
    t_same_cycle();
    t_spare_bits();
    t_ignored();
    t_read_lanes();
    t_write_lane(16'h3010, 1'b0);
    t_write_lane(16'h5010, 1'b1);
    t_reset_again();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule